// File: doc/BRIEF.md
# 64-bit Global Timer with Comparator

This peripheral keeps a free-running 64-bit count that advances on ticks taken from the peripheral clock through a programmable divider. Software reaches it through a small 32-bit register port. The count and a 64-bit compare value are each split into a low word and a high word. An event flag is raised when the count reaches the compare value or is already above it. The flag can be routed to an interrupt line.

An auto-increment mode adds a programmable 32-bit step to the compare value each time the event fires, so periodic events need no software action. Reads have no side effects. Reading one word of the count does not freeze the other word. Software detects a carry by reading high, then low, then high again.

The register port is a plain write strobe with a word address. Read data follows the address combinationally. Word addresses are 0 count low, 1 count high, 2 control, 3 status, 4 compare low, 5 compare high and 6 step. Unmapped addresses read as zero.

Top module: `gtimer_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Words 0 and 1 read and write the low and high halves of the count. A carry out of the low half shows in the high half on the following read, so the read order high, low, high exposes it.
- R3: Control bit 0 enables counting. While it is clear the count holds its value unless software writes it.
- R4: Control bits 15:8 hold the prescale value P. While running, the count rises once every P+1 clocks, so N clocks after enabling it has risen by floor(N/(P+1)). P may be changed while the timer runs.
- R5: Status bit 0 (the event flag) sets when the count is greater than or equal to the compare value (words 4 and 5). Equality is not required.
- R6: While control bit 1 (compare enable) is clear, the event flag never sets.
- R7: One compare match sets the flag once. After it is cleared, the flag stays clear while the same match persists.
- R8: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear has no effect.
- R9: If an event fires in the same cycle that a clear is written, the flag ends up set.
- R10: `irq` is high exactly while the event flag and control bit 2 (interrupt enable) are both set.
- R11: With control bit 3 (auto-increment) set, each event adds the word-6 step, zero-extended, to the compare value, and the next crossing fires again.
- R12: After an auto-increment, if the count is still at or above the new compare value, another event fires on the next cycle. A compare value far behind the count therefore catches up one step per clock until it passes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address of the register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Event interrupt request |

## Verification
The bench builds the block with its defaults: 32-bit halves and an 8-bit prescale field. The widest divider setting (256 clocks per count) can therefore be measured in a few hundred cycles. Carry between the halves is reached by preloading the count just below a low-word wrap rather than by counting there. Compare matches, set-versus-clear collisions and the auto-increment catch-up are placed at exact cycles by preloading small count and compare values.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_CTRL   = 3'd2,
    A_STAT   = 3'd3,
    A_CMP_LO = 3'd4,
    A_CMP_HI = 3'd5,
    A_STEP   = 3'd6
  } reg_addr_e;

  localparam int CB_RUN  = 0;
  localparam int CB_CEN  = 1;
  localparam int CB_IEN  = 2;
  localparam int CB_AUTO = 3;
  localparam int CB_PSC  = 8;
endpackage

// File: rtl/gtimer_prescale.sv
module gtimer_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic             wrap;

  // >= rather than == so lowering psc mid-count cannot skip a wrap
  assign wrap = (div_q >= psc);
  assign tick = run & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  div_q <= '0;
    else if (wrap)       div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/gtimer_counter.sv
module gtimer_counter #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (wr_lo) count[HALF_W-1:0] <= wdata;
    else if (wr_hi) count[2*HALF_W-1:HALF_W] <= wdata;
    else if (tick)  count <= count + 1'b1;
  end
endmodule

// File: rtl/gtimer_compare.sv
module gtimer_compare #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*HALF_W-1:0]   count,
  input  logic                  cmp_en,
  input  logic                  auto_en,
  input  logic [HALF_W-1:0]     step,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   cmp,
  output logic                  fire
);
  logic ge;
  logic ge_q;
  logic adv_q;

  assign ge   = (count >= cmp);
  // fire on a fresh crossing, or re-check right after an advance
  assign fire = cmp_en & ge & (~ge_q | adv_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp   <= '0;
      ge_q  <= 1'b0;
      adv_q <= 1'b0;
    end else begin
      ge_q  <= cmp_en & ge;
      adv_q <= fire & auto_en;
      if (wr_lo)                cmp[HALF_W-1:0] <= wdata;
      else if (wr_hi)           cmp[2*HALF_W-1:HALF_W] <= wdata;
      else if (fire && auto_en) cmp <= cmp + {{HALF_W{1'b0}}, step};
    end
  end
endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
  import gtimer_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * HALF_W;

  logic             run_q, cen_q, ien_q, auto_q;
  logic [PSC_W-1:0] psc_q;
  logic [HALF_W-1:0] step_q;
  logic             evt_flag;
  logic             tick, fire, clr;
  logic             wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi;
  logic [CNT_W-1:0] count, cmp;
  logic [HALF_W-1:0] ctrl_rd;

  assign wr_cnt_lo = reg_wr && (reg_addr == A_CNT_LO);
  assign wr_cnt_hi = reg_wr && (reg_addr == A_CNT_HI);
  assign wr_cmp_lo = reg_wr && (reg_addr == A_CMP_LO);
  assign wr_cmp_hi = reg_wr && (reg_addr == A_CMP_HI);
  assign clr       = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; cen_q <= 1'b0; ien_q <= 1'b0; auto_q <= 1'b0;
      psc_q <= '0;   step_q <= '0;  evt_flag <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        run_q  <= reg_wdata[CB_RUN];
        cen_q  <= reg_wdata[CB_CEN];
        ien_q  <= reg_wdata[CB_IEN];
        auto_q <= reg_wdata[CB_AUTO];
        psc_q  <= reg_wdata[CB_PSC +: PSC_W];
      end
      if (reg_wr && reg_addr == A_STEP) step_q <= reg_wdata;
      if (fire)     evt_flag <= 1'b1;
      else if (clr) evt_flag <= 1'b0;
    end
  end

  gtimer_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .psc(psc_q), .tick(tick)
  );

  gtimer_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(reg_wdata), .count(count)
  );

  gtimer_compare #(.HALF_W(HALF_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .count(count), .cmp_en(cen_q), .auto_en(auto_q),
    .step(step_q), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wdata(reg_wdata),
    .cmp(cmp), .fire(fire)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_RUN]  = run_q;
    ctrl_rd[CB_CEN]  = cen_q;
    ctrl_rd[CB_IEN]  = ien_q;
    ctrl_rd[CB_AUTO] = auto_q;
    ctrl_rd[CB_PSC +: PSC_W] = psc_q;
  end

  always_comb begin
    case (reg_addr)
      A_CNT_LO: reg_rdata = count[HALF_W-1:0];
      A_CNT_HI: reg_rdata = count[CNT_W-1:HALF_W];
      A_CTRL:   reg_rdata = ctrl_rd;
      A_STAT:   reg_rdata = {{(HALF_W-1){1'b0}}, evt_flag};
      A_CMP_LO: reg_rdata = cmp[HALF_W-1:0];
      A_CMP_HI: reg_rdata = cmp[CNT_W-1:HALF_W];
      A_STEP:   reg_rdata = step_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = evt_flag & ien_q;
endmodule

// File: rtl/gtimer_checks.sv
module gtimer_checks #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cen,
  input logic             ien,
  input logic             flag,
  input logic             fire,
  input logic             clr,
  input logic             cnt_wr,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp
);
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run && !cnt_wr) |-> count == $past(count));

  // R5
  flag_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(count >= cmp));

  // R6
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(cen));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr && !fire) |-> !flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag && !clr) |-> flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
endmodule

bind gtimer_top gtimer_checks #(.CNT_W(2 * HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .cen(cen_q), .ien(ien_q),
  .flag(evt_flag), .fire(fire), .clr(clr), .cnt_wr(wr_cnt_lo | wr_cnt_hi),
  .irq(irq), .count(count), .cmp(cmp)
);

// File: tb/gtimer_top_bench.sv
module gtimer_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gtimer_top u_gtimer_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {psc, clocks to wait, expected count}
  localparam logic [55:0] VEC [5] = '{
    {8'd0,   16'd10,  32'd10},
    {8'd1,   16'd10,  32'd5},
    {8'd3,   16'd13,  32'd3},
    {8'd7,   16'd40,  32'd5},
    {8'd255, 16'd600, 32'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tasks start and end at a negedge; each spans exactly one posedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preset(input logic [31:0] clo, input logic [31:0] chi,
                        input logic [31:0] klo);
    wr(3'd2, 32'h0);
    wr(3'd0, clo); wr(3'd1, chi);
    wr(3'd4, klo); wr(3'd5, 32'h0);
    idle(2);
    wr(3'd3, 32'h1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); check("R1 reg", v, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R4 prescale table
    for (int i = 0; i < 5; i++) begin
      wr(3'd2, 32'h0); wr(3'd0, 32'h0); wr(3'd1, 32'h0);
      wr(3'd2, {16'h0, VEC[i][55:48], 8'h01});
      idle(int'(VEC[i][47:32]));
      rd(3'd0, v); check("R4 count", v, VEC[i][31:0]);
    end
    rd(3'd2, v); check("R4 ctrl readback", v, 32'h0000_FF01);

    // R2 carry observed by high, low, high
    wr(3'd2, 32'h0); wr(3'd0, 32'hFFFF_FFFE); wr(3'd1, 32'h5);
    wr(3'd2, 32'h1);
    rd(3'd1, v); check("R2 hi before", v, 32'h5);
    rd(3'd0, v); check("R2 lo", v, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R2 hi after", v, 32'h6);
    rd(3'd0, v); check("R2 lo wrapped", v, 32'h1);

    // R3 / R6: stopped timer, compare disabled, count past compare
    preset(32'd100, 32'd0, 32'd50);
    idle(4);
    rd(3'd0, v); check("R3 count held", v, 32'd100);
    rd(3'd3, v); check("R6 no flag while disabled", v, 32'h0);

    // R5: enable compare with count already above it
    wr(3'd2, 32'h2);
    rd(3'd3, v); check("R5 not yet", v, 32'h0);
    rd(3'd3, v); check("R5 flag on >=", v, 32'h1);
    check("R10 irq off", {31'b0, irq}, 32'h0);
    // R8 write 0 no effect
    wr(3'd3, 32'h0); rd(3'd3, v); check("R8 write0 keeps", v, 32'h1);
    // R10 interrupt enable
    wr(3'd2, 32'h6); #1; check("R10 irq on", {31'b0, irq}, 32'h1);
    // R8 clear, R7 no second event while match persists
    wr(3'd3, 32'h1); #1; check("R10 irq follows clear", {31'b0, irq}, 32'h0);
    rd(3'd3, v); check("R8 cleared", v, 32'h0);
    idle(5);
    rd(3'd3, v); check("R7 single event", v, 32'h0);

    // R9: clear written in the firing cycle
    preset(32'd0, 32'd0, 32'd10);
    wr(3'd2, 32'h3);
    idle(10);
    wr(3'd3, 32'h1);
    rd(3'd3, v); check("R9 set beats clear", v, 32'h1);

    // R11 auto-increment
    preset(32'd0, 32'd0, 32'd20);
    wr(3'd6, 32'd16);
    wr(3'd2, 32'hB);
    idle(25);
    rd(3'd4, v); check("R11 cmp advanced", v, 32'd36);
    rd(3'd3, v); check("R11 first event", v, 32'h1);
    wr(3'd3, 32'h1);
    idle(13);
    rd(3'd3, v); check("R11 periodic event", v, 32'h1);
    rd(3'd4, v); check("R11 cmp advanced again", v, 32'd52);

    // R12 catch-up with a small step
    preset(32'd100, 32'd0, 32'd50);
    wr(3'd6, 32'd1);
    wr(3'd2, 32'hA);
    idle(60);
    rd(3'd4, v); check("R12 caught up", v, 32'd101);
    rd(3'd5, v); check("R12 high word", v, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule